// File: doc/BRIEF.md
# Windowed Data Address Mapper

This block sits between a processor core's 16-bit data address bus and the memory fabric. It classifies every data address into one of four physical targets and produces the physical offset that the chosen memory should use. The four targets are internal data RAM, the internal I/O and data area at the top of the space, a 16 KB page of instruction memory, and a 16 KB page inside one 128 KB segment of a segmented unified memory.

The upper-middle quarter of the address space, 0x8000 to 0xBFFF, is a movable window. Software picks where it points by writing a 16-bit window-control register, which it can also read back. Bit 12 of that register chooses instruction memory. Bits [3:0] give the instruction page. When bit 12 is clear, bits [9:3] give the unified segment and bits [2:0] give the 16 KB page inside it.

A per-segment presence mask comes from outside the block. The mapper raises a fault flag when the window selects a segment that is marked absent. It also raises a warning flag for accesses in the top region that fall outside the sixteen-word block at 0xFF00 to 0xFF0F. Translation is combinational, and only the window-control register holds state.

Top module: `dwin_addr_xlate`

## Requirements
- R1: The window-control register is 0x0000 after synchronous reset. A write (`map_wr_en`=1) is visible on `map_rd_data` after the next rising clock edge, and the register keeps its value in every cycle without a write.
- R2: An address below 0x8000 gives region code 0 (data RAM). The offset equals the address zero-extended, and the segment is 0.
- R3: An address of 0xC000 or above gives region code 1 (I/O and data). The offset equals the address zero-extended, and the segment is 0.
- R4: `io_warn` is 1 exactly when the region code is 1 and the address lies outside 0xFF00 to 0xFF0F. It is 0 for every other address.
- R5: An address in 0x8000 to 0xBFFF with control bit 12 set gives region code 2 (instruction memory) and segment 0. The offset is control[3:0] × 0x4000 plus address[13:0]. Control bits [15:13] and [11:4] have no effect on this result.
- R6: An address in 0x8000 to 0xBFFF with control bit 12 clear gives region code 3 (unified memory). The segment is control[9:3], and the offset is control[2:0] × 0x4000 plus address[13:0]. Control bits [15:13] and [11:10] have no effect on this result.
- R7: `seg_absent` is 1 exactly when the region code is 3 and bit `tgt_seg` of `seg_present` is 0. It is 0 for every other region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_wr_en | input | 1 | Write strobe for the window-control register |
| map_wr_data | input | 16 | Value to write into the window-control register |
| map_rd_data | output | 16 | Current window-control register value |
| addr_in | input | 16 | Data address from the core |
| seg_present | input | 128 | One bit per unified segment, 1 = segment exists |
| tgt_region | output | 2 | 0 data RAM, 1 I/O and data, 2 instruction memory, 3 unified memory |
| tgt_seg | output | 7 | Unified segment number (0 outside region 3) |
| tgt_offset | output | 18 | Physical byte offset inside the target |
| io_warn | output | 1 | Top-region access outside 0xFF00 to 0xFF0F |
| seg_absent | output | 1 | Window selects a segment marked absent |

## Verification
The bound checker watches, on every cycle, the register's reset value, write landing and hold. It also checks that the flags only appear in the regions they belong to, and that the segment and offset low bits track the control register and the address. The exact page arithmetic, the boundary addresses 0x7FFF, 0x8000, 0xBFFF, 0xC000, 0xFF0F and 0xFF10, and the proof that ignored control bits really have no effect come only from the bench's vectors. The same holds for the absent-segment fault under different presence masks.

// File: rtl/dwin_pkg.sv
package dwin_pkg;

    localparam int DADDR_W    = 16;              // core data address width
    localparam int MAP_W      = 16;              // window-control register width
    localparam int WIN_W      = 14;              // 16 KB window offset bits
    localparam int IPAGE_W    = 4;               // instruction page select bits
    localparam int UPAGE_W    = 3;               // page inside a unified segment
    localparam int SEG_W      = 7;               // unified segment number bits
    localparam int NUM_SEGS   = 1 << SEG_W;
    localparam int OFS_W      = WIN_W + IPAGE_W; // widest physical offset
    localparam int MAP_IMEM_BIT = 12;
    localparam int MAP_SEG_LSB  = UPAGE_W;
    localparam logic [DADDR_W-5:0] IO_QUIET_BLK = 12'hFF0;

    typedef enum logic [1:0] {
        TGT_DRAM = 2'd0,
        TGT_IO   = 2'd1,
        TGT_IMEM = 2'd2,
        TGT_UMEM = 2'd3
    } tgt_e;

    function automatic tgt_e classify(input logic [DADDR_W-1:0] a, input logic imem_sel);
        if (!a[DADDR_W-1])
            return TGT_DRAM;
        else if (a[DADDR_W-2])
            return TGT_IO;
        else if (imem_sel)
            return TGT_IMEM;
        else
            return TGT_UMEM;
    endfunction

    function automatic logic [SEG_W-1:0] map_seg(input logic [MAP_W-1:0] m);
        return m[MAP_SEG_LSB +: SEG_W];
    endfunction

endpackage

// File: rtl/dwin_map_reg.sv
module dwin_map_reg
    import dwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [MAP_W-1:0] wr_data,
    output logic [MAP_W-1:0] map_q
);
    always_ff @(posedge clk) begin
        if (rst)
            map_q <= '0;
        else if (wr_en)
            map_q <= wr_data;
    end
endmodule

// File: rtl/dwin_region_dec.sv
module dwin_region_dec
    import dwin_pkg::*;
(
    input  logic [DADDR_W-1:0] addr,
    input  logic               imem_sel,
    output tgt_e               region,
    output logic               io_warn
);
    always_comb begin
        region  = classify(addr, imem_sel);
        io_warn = (region == TGT_IO) && (addr[DADDR_W-1:4] != IO_QUIET_BLK);
    end
endmodule

// File: rtl/dwin_offset_gen.sv
module dwin_offset_gen
    import dwin_pkg::*;
(
    input  logic [DADDR_W-1:0]  addr,
    input  tgt_e                region,
    input  logic [MAP_W-1:0]    map_q,
    input  logic [NUM_SEGS-1:0] seg_present,
    output logic [SEG_W-1:0]    seg,
    output logic [OFS_W-1:0]    ofs,
    output logic                seg_absent
);
    logic [SEG_W-1:0] sel_seg;
    logic             unused_map_bits;

    assign sel_seg         = map_seg(map_q);
    assign unused_map_bits = ^{map_q[MAP_W-1:MAP_IMEM_BIT], map_q[MAP_SEG_LSB+SEG_W +: 2]};

    always_comb begin
        seg        = '0;
        seg_absent = 1'b0;
        ofs        = {{(OFS_W-DADDR_W){1'b0}}, addr};
        case (region)
            TGT_IMEM: ofs = {map_q[IPAGE_W-1:0], addr[WIN_W-1:0]};
            TGT_UMEM: begin
                seg        = sel_seg;
                seg_absent = !seg_present[sel_seg];
                ofs        = {{(OFS_W-UPAGE_W-WIN_W){1'b0}},
                              map_q[UPAGE_W-1:0], addr[WIN_W-1:0]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dwin_addr_xlate.sv
module dwin_addr_xlate
    import dwin_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                map_wr_en,
    input  logic [MAP_W-1:0]    map_wr_data,
    output logic [MAP_W-1:0]    map_rd_data,
    input  logic [DADDR_W-1:0]  addr_in,
    input  logic [NUM_SEGS-1:0] seg_present,
    output logic [1:0]          tgt_region,
    output logic [SEG_W-1:0]    tgt_seg,
    output logic [OFS_W-1:0]    tgt_offset,
    output logic                io_warn,
    output logic                seg_absent
);
    logic [MAP_W-1:0] map_q;
    tgt_e             region;

    dwin_map_reg u_map (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (map_wr_en),
        .wr_data (map_wr_data),
        .map_q   (map_q)
    );

    dwin_region_dec u_dec (
        .addr     (addr_in),
        .imem_sel (map_q[MAP_IMEM_BIT]),
        .region   (region),
        .io_warn  (io_warn)
    );

    dwin_offset_gen u_ofs (
        .addr        (addr_in),
        .region      (region),
        .map_q       (map_q),
        .seg_present (seg_present),
        .seg         (tgt_seg),
        .ofs         (tgt_offset),
        .seg_absent  (seg_absent)
    );

    assign map_rd_data = map_q;
    assign tgt_region  = region;
endmodule

// File: rtl/dwin_addr_xlate_chk.sv
module dwin_addr_xlate_chk
    import dwin_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                map_wr_en,
    input logic [MAP_W-1:0]    map_wr_data,
    input logic [MAP_W-1:0]    map_rd_data,
    input logic [DADDR_W-1:0]  addr_in,
    input logic [NUM_SEGS-1:0] seg_present,
    input logic [1:0]          tgt_region,
    input logic [SEG_W-1:0]    tgt_seg,
    input logic [OFS_W-1:0]    tgt_offset,
    input logic                io_warn,
    input logic                seg_absent
);
    logic seen_rst;
    always_ff @(posedge clk) begin
        if (rst) seen_rst <= 1'b1;
        else if (seen_rst !== 1'b1) seen_rst <= 1'b0;
    end

    // R1: register is zero in the first cycle after reset
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
        (seen_rst === 1'b1 && $past(rst)) |-> map_rd_data == '0);

    // R1: a write lands on the next edge
    a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
        map_wr_en |=> map_rd_data == $past(map_wr_data));

    // R1: no write, no change
    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        !map_wr_en |=> $stable(map_rd_data));

    // R2: low half goes straight to data RAM
    a_r2_low_direct: assert property (@(posedge clk) disable iff (rst)
        !addr_in[DADDR_W-1] |-> (tgt_region == 2'd0 &&
            tgt_offset == {{(OFS_W-DADDR_W){1'b0}}, addr_in} && tgt_seg == '0));

    // R4: warning only in the top region
    a_r4_warn_region: assert property (@(posedge clk) disable iff (rst)
        io_warn |-> (tgt_region == 2'd1 && addr_in[DADDR_W-1:DADDR_W-2] == 2'b11));

    // R5: instruction window follows control bit and address low bits
    a_r5_imem_window: assert property (@(posedge clk) disable iff (rst)
        tgt_region == 2'd2 |-> (map_rd_data[MAP_IMEM_BIT] &&
            tgt_offset[WIN_W-1:0] == addr_in[WIN_W-1:0]));

    // R6: unified segment comes from the control register
    a_r6_umem_seg: assert property (@(posedge clk) disable iff (rst)
        tgt_region == 2'd3 |-> (tgt_seg == map_rd_data[MAP_SEG_LSB +: SEG_W] &&
            tgt_offset[WIN_W-1:0] == addr_in[WIN_W-1:0]));

    // R7: absent fault only for a unified access to a missing segment
    a_r7_absent_fault: assert property (@(posedge clk) disable iff (rst)
        seg_absent |-> (tgt_region == 2'd3 && !seg_present[tgt_seg]));
endmodule

bind dwin_addr_xlate dwin_addr_xlate_chk u_chk (.*);

// File: tb/dwin_addr_xlate_tb.sv
module dwin_addr_xlate_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         map_wr_en = 1'b0;
    logic [15:0]  map_wr_data = '0;
    logic [15:0]  map_rd_data;
    logic [15:0]  addr_in = '0;
    logic [127:0] seg_present;
    logic [1:0]   tgt_region;
    logic [6:0]   tgt_seg;
    logic [17:0]  tgt_offset;
    logic         io_warn;
    logic         seg_absent;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    dwin_addr_xlate dut_i (.*);

    always #4 clk = ~clk;

    // vector: map(16) addr(16) region(2) seg(7) offset(18) warn(1) absent(1)
    localparam int NV = 18;
    localparam logic [60:0] VEC [NV] = '{
        {16'h0000, 16'h0000, 2'd0, 7'd0,   18'h00000, 1'b0, 1'b0},
        {16'h0000, 16'h7FFF, 2'd0, 7'd0,   18'h07FFF, 1'b0, 1'b0},
        {16'h0000, 16'hC000, 2'd1, 7'd0,   18'h0C000, 1'b1, 1'b0},
        {16'h0000, 16'hFF00, 2'd1, 7'd0,   18'h0FF00, 1'b0, 1'b0},
        {16'h0000, 16'hFF0F, 2'd1, 7'd0,   18'h0FF0F, 1'b0, 1'b0},
        {16'h0000, 16'hFF10, 2'd1, 7'd0,   18'h0FF10, 1'b1, 1'b0},
        {16'h0000, 16'hFFFF, 2'd1, 7'd0,   18'h0FFFF, 1'b1, 1'b0},
        {16'h1000, 16'h8000, 2'd2, 7'd0,   18'h00000, 1'b0, 1'b0},
        {16'h100F, 16'hBFFF, 2'd2, 7'd0,   18'h3FFFF, 1'b0, 1'b0},
        {16'h1005, 16'h9234, 2'd2, 7'd0,   18'h15234, 1'b0, 1'b0},
        {16'h1FF3, 16'h8004, 2'd2, 7'd0,   18'h0C004, 1'b0, 1'b0},
        {16'h0000, 16'h8000, 2'd3, 7'd0,   18'h00000, 1'b0, 1'b0},
        {16'h000F, 16'hA001, 2'd3, 7'd1,   18'h1E001, 1'b0, 1'b0},
        {16'h03FF, 16'hBFFF, 2'd3, 7'd127, 18'h1FFFF, 1'b0, 1'b0},
        {16'h0018, 16'h8010, 2'd3, 7'd3,   18'h00010, 1'b0, 1'b1},
        {16'hE3FA, 16'h8123, 2'd3, 7'd127, 18'h08123, 1'b0, 1'b0},
        {16'h0010, 16'h8000, 2'd3, 7'd2,   18'h00000, 1'b0, 1'b0},
        {16'h0400, 16'h8000, 2'd3, 7'd0,   18'h00000, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            report();
        end
    end

    task automatic write_map(input logic [15:0] v);
        @(negedge clk);
        map_wr_en   = 1'b1;
        map_wr_data = v;
        @(negedge clk);
        map_wr_en   = 1'b0;
        #1;
    endtask

    initial begin
        seg_present = '0;
        seg_present[0] = 1'b1; seg_present[1] = 1'b1;
        seg_present[2] = 1'b1; seg_present[127] = 1'b1;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset value", 32'(map_rd_data), 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [15:0] m, a;
            logic [1:0]  er;
            logic [6:0]  es;
            logic [17:0] eo;
            logic        ew, ea;
            string       rt;
            {m, a, er, es, eo, ew, ea} = VEC[i];
            addr_in = a;
            write_map(m);
            case (er)
                2'd0:    rt = "R2";
                2'd1:    rt = "R3";
                2'd2:    rt = "R5";
                default: rt = "R6";
            endcase
            check($sformatf("R1 readback v%0d", i), 32'(map_rd_data), 32'(m));
            check($sformatf("%s region v%0d", rt, i), 32'(tgt_region), 32'(er));
            check($sformatf("%s segment v%0d", rt, i), 32'(tgt_seg), 32'(es));
            check($sformatf("%s offset v%0d", rt, i), 32'(tgt_offset), 32'(eo));
            check($sformatf("R4 warn v%0d", i), 32'(io_warn), 32'(ew));
            check($sformatf("R7 absent v%0d", i), 32'(seg_absent), 32'(ea));
        end

        // R1: hold without write
        @(negedge clk);
        map_wr_data = 16'hABCD;
        repeat (2) @(negedge clk);
        #1;
        check("R1 hold", 32'(map_rd_data), 32'h0400);

        // R7: empty presence mask faults a window access, not a RAM access
        seg_present = '0;
        write_map(16'h0000);
        addr_in = 16'h8000;
        #1;
        check("R7 absent all-missing", 32'(seg_absent), 32'h1);
        addr_in = 16'h1234;
        #1;
        check("R7 no fault in RAM", 32'(seg_absent), 32'h0);
        check("R2 offset under empty mask", 32'(tgt_offset), 32'h1234);
        addr_in = 16'hFF05;
        #1;
        check("R7 no fault in I/O", 32'(seg_absent), 32'h0);
        check("R4 quiet block", 32'(io_warn), 32'h0);

        // R1: reset clears a written value
        write_map(16'h1234);
        check("R1 pre-reset write", 32'(map_rd_data), 32'h1234);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset clears", 32'(map_rd_data), 32'h0);

        done = 1;
        report();
    end
endmodule